// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback counter of a frequency synthesiser loop. It runs on the digitised RF clock and divides it by a 17-bit ratio word. The word is split into a 13-bit main count M and a 4-bit swallow count A. A divide-by-16/17 prescaler is modelled in logic, and its modulus is chosen by whether the swallow count is still running. This gives a total division of 16·M + A. Once per divide cycle the block emits a one-clock pulse for the phase and frequency comparator.

The same pulse marks the divide-cycle boundary. The ratio input is sampled only on that boundary, so a new word never cuts a cycle short or stretches it, and the loop retunes smoothly. The pulse can also serve elsewhere as the load strobe for pending control words. For test, a half-rate copy of the divider output can be routed to an output pin.

Top module: `pulse_swallow_div`

## Requirements
- R1: While rst_ni is low, tc_o and half_o are 0. Reset leaves a ratio word of zero loaded, so the first tc_o pulse appears exactly 16 clocks after rst_ni rises.
- R2: With M = ratio_i[16:4], A = ratio_i[3:0] and M ≥ A ≥ 0, M ≥ 1, consecutive tc_o pulses are exactly 16·M + A clocks apart.
- R3: Each tc_o pulse is exactly one clock wide.
- R4: ratio_i is sampled only on the clock edge that raises tc_o, and the sampled word sets the length of the cycle that follows. A change of ratio_i at any other time has no effect on the cycle in progress. This holds even when the change lands on the last clock before the boundary.
- R5: An M field of 0 behaves exactly like M = 1. With M = 1 the period is 16 clocks when A = 0 and 17 clocks for any nonzero A.
- R6: When 1 ≤ M < A, the block keeps counting and the period is 17·M clocks.
- R7: An internal toggle is cleared by reset and flips on the same edge that raises tc_o. half_o shows the toggle while test_en_i is 1 and is forced to 0 while test_en_i is 0. Lowering test_en_i does not stop the toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Digitised RF input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 17 | Divide word: M in bits 16:4, A in bits 3:0 |
| test_en_i | input | 1 | Enables the half-rate test output |
| tc_o | output | 1 | One-clock pulse per divide cycle, also the reload strobe |
| half_o | output | 1 | Divider output halved, gated by test_en_i |

## Verification
The ratio reload and the end of the current cycle happen on the same clock edge. The half-rate toggle also flips on that edge. The bench provokes the coincidence by counting from one pulse and changing ratio_i on the last clock before the next pulse is due. It then requires that the finishing cycle keeps its old length and that the following cycle takes the new one. The half-rate output is sampled in the cycle where tc_o is high and must already show the flipped value at that point.

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int M_W = 13,
  parameter int A_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [M_W+A_W-1:0] ratio_i,
  input  logic               test_en_i,
  output logic               tc_o,
  output logic               half_o
);
  localparam int TOT_W = M_W + A_W;
  localparam int P_W = A_W + 1;
  localparam logic [P_W-1:0] LAST_LO = P_W'((1 << A_W) - 1);
  localparam logic [P_W-1:0] LAST_HI = P_W'(1 << A_W);

  logic [P_W-1:0] pcnt;
  logic [M_W-1:0] mcnt;
  logic [A_W-1:0] acnt;
  logic           tc_q;
  logic           tog;
  logic           swallow, pend, last;

  assign swallow = acnt != '0;
  assign pend    = pcnt == (swallow ? LAST_HI : LAST_LO);
  assign last    = pend && (mcnt <= M_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt <= '0;
      mcnt <= '0;
      acnt <= '0;
      tc_q <= 1'b0;
      tog  <= 1'b0;
    end else begin
      tc_q <= last;
      if (last) begin
        pcnt <= '0;
        mcnt <= ratio_i[TOT_W-1:A_W];
        acnt <= ratio_i[A_W-1:0];
        tog  <= ~tog;
      end else if (pend) begin
        pcnt <= '0;
        mcnt <= mcnt - M_W'(1);
        if (swallow) acnt <= acnt - A_W'(1);
      end else begin
        pcnt <= pcnt + P_W'(1);
      end
    end
  end

  assign tc_o   = tc_q;
  assign half_o = test_en_i & tog;
endmodule

module pulse_swallow_div_chk #(
  parameter int M_W = 13,
  parameter int A_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [M_W+A_W-1:0] ratio_i,
  input logic               test_en_i,
  input logic               tc_o,
  input logic               half_o
);
  localparam int BASE = 1 << A_W;

  logic [M_W+A_W-1:0] prev_ratio;
  logic [31:0]        cnt;
  logic [31:0]        expect_len;

  function automatic logic [31:0] period_of(input logic [M_W+A_W-1:0] r);
    int m, a;
    m = int'(r[M_W+A_W-1:A_W]);
    a = int'(r[A_W-1:0]);
    if (m < 1) m = 1;
    if (a > m) return 32'((BASE + 1) * m);
    return 32'(BASE * m + a);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ratio <= '0;
      cnt        <= '0;
      expect_len <= 32'(BASE);
    end else begin
      prev_ratio <= ratio_i;
      if (tc_o) begin
        cnt        <= 32'd1;
        expect_len <= period_of(prev_ratio);
      end else begin
        cnt <= cnt + 32'd1;
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i) !rst_ni |-> (!tc_o && !half_o));

  // R2, with R5 and R6 folded into the expected length
  p_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> cnt == expect_len);

  p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !tc_o);

  p_half_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && $past(test_en_i) && !tc_o) |-> half_o == $past(half_o));

  p_half_flip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && $past(test_en_i) && tc_o) |-> half_o != $past(half_o));
endmodule

bind pulse_swallow_div pulse_swallow_div_chk #(.M_W(M_W), .A_W(A_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ratio_i(ratio_i),
  .test_en_i(test_en_i), .tc_o(tc_o), .half_o(half_o)
);

// File: tb/pulse_swallow_div_test.sv
module pulse_swallow_div_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [16:0] ratio_i = '0;
  logic        test_en_i = 1'b1;
  logic        tc_o, half_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk_i = ~clk_i;

  pulse_swallow_div uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ratio_i(ratio_i),
    .test_en_i(test_en_i), .tc_o(tc_o), .half_o(half_o)
  );

  // {M, A, expected period}
  localparam int NV = 11;
  localparam logic [33:0] VEC [NV] = '{
    {13'd5,   4'd3,  17'd83},    // R2
    {13'd2,   4'd0,  17'd32},    // R2
    {13'd4,   4'd4,  17'd68},    // R2 M equal to A
    {13'd15,  4'd15, 17'd255},   // R2
    {13'd100, 4'd7,  17'd1607},  // R2
    {13'd1,   4'd1,  17'd17},    // R2 smallest swallow
    {13'd0,   4'd0,  17'd16},    // R5
    {13'd1,   4'd0,  17'd16},    // R5
    {13'd0,   4'd3,  17'd17},    // R5
    {13'd2,   4'd9,  17'd34},    // R6
    {13'd3,   4'd15, 17'd51}     // R6
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_tc();
    do @(negedge clk_i); while (!tc_o);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (n == 1) chk(!tc_o, "R3 pulse width", int'(tc_o), 0);
    end while (!tc_o);
  endtask

  initial begin
    forever begin
      @(negedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int n, k;
    string tag;
    logic h;

    repeat (4) @(negedge clk_i);
    chk(!tc_o, "R1 tc in reset", int'(tc_o), 0);
    chk(!half_o, "R1 half in reset", int'(half_o), 0);
    rst_ni = 1'b1;
    n = 0;
    do begin @(negedge clk_i); n++; end while (!tc_o);
    chk(n == 16, "R1 first pulse", n, 16);

    for (int i = 0; i < NV; i++) begin
      tag = (i < 6) ? "R2 table" : (i < 9) ? "R5 table" : "R6 table";
      ratio_i = VEC[i][33:17];
      wait_tc();
      measure(n);
      chk(n == int'(VEC[i][16:0]), tag, n, int'(VEC[i][16:0]));
    end

    // R4: change mid-cycle
    ratio_i = {13'd5, 4'd3};
    wait_tc();
    n = 0;
    repeat (20) begin @(negedge clk_i); n++; end
    ratio_i = {13'd2, 4'd0};
    do begin @(negedge clk_i); n++; end while (!tc_o);
    chk(n == 83, "R4 mid-cycle change ignored", n, 83);
    measure(n);
    chk(n == 32, "R4 new word applied", n, 32);

    // R4: change on the last clock before the boundary
    n = 0;
    repeat (31) begin @(negedge clk_i); n++; end
    ratio_i = {13'd4, 4'd4};
    do begin @(negedge clk_i); n++; end while (!tc_o);
    chk(n == 32, "R4 boundary cycle length", n, 32);
    measure(n);
    chk(n == 68, "R4 boundary word taken", n, 68);

    // R7: half-rate output
    ratio_i = {13'd1, 4'd0};
    wait_tc();
    h = half_o;
    for (int j = 0; j < 3; j++) begin
      measure(n);
      chk(half_o == ~h, "R7 toggle on pulse", int'(half_o), int'(~h));
      h = half_o;
    end
    test_en_i = 1'b0;
    #0.1;
    chk(!half_o, "R7 gated low", int'(half_o), 0);
    k = 0;
    for (int j = 0; j < 3; j++) begin
      measure(n);
      k++;
      chk(!half_o, "R7 gated low at pulse", int'(half_o), 0);
    end
    test_en_i = 1'b1;
    #0.1;
    chk(half_o == (h ^ k[0]), "R7 toggle kept running", int'(half_o), int'(h ^ k[0]));
    h = half_o;
    measure(n);
    chk(half_o == ~h, "R7 toggle after re-enable", int'(half_o), int'(~h));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule